// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous internal bus and an external asynchronous static RAM that is 16 bits wide. The RAM has 18 address lines, two chip selects of opposite polarity, output and write strobes, and two active-low byte-lane enables. The internal side presents one word request at a time: a request line, a direction bit, an address, write data and a byte-lane mask. The block then produces every memory strobe from registers, so that each edge lands on a clock boundary. It returns a one-cycle completion pulse, together with the read data for reads. The data pins are reached through separate output, input and driver-enable signals; the tri-state pad itself sits outside the block.

All timing comes from nanosecond parameters and the clock period. The nanosecond values are the write pulse width, the data setup before the end of a write, the write cycle time, the address access time and the time the memory keeps driving its pins after it is released. Each one is turned into a whole number of cycles, rounded up. Writes hold the output strobe inactive from start to finish. After a read, the block waits out the memory's release time before it turns on its own data drivers. A request that enables neither byte lane completes at once and asserts no strobe.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and after it is released, the memory side is idle: mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_be_n=11, mem_dq_oe=0. On the request side done=0 and idle=1.
- R2: The chip selects (mem_ce1_n=0 with mem_ce2=1) are asserted only from the edge that accepts a request with at least one lane enabled until the edge that completes it. While the chip is deselected, mem_be_n is 11 and both strobes are high.
- R3: A read (req_we=0) drives mem_oe_n low with mem_we_n high from its acceptance edge for RD_CYC = ceil(T_AA/Tclk)+1 cycles. At the edge that ends this window, mem_dq_in is captured into rdata, the chip is deselected and done is high for one cycle. At that edge rdata is valid.
- R4: A write (req_we=1) places the address and chip selects at least one cycle before mem_we_n falls. mem_we_n then stays low for WP_CYC = max(ceil(T_WP/Tclk), ceil(T_DW/Tclk)) cycles. After that the address and selects stay unchanged, with mem_we_n high, for HOLD_CYC = max(1, ceil(T_WC/Tclk) - WP_CYC - 1) cycles, and then done pulses.
- R5: mem_oe_n stays high for the whole of every write.
- R6: mem_dq_oe is high exactly while mem_we_n is low and during the following hold cycles. While it is high, mem_dq_out equals the request's write data.
- R7: After mem_oe_n rises at the end of a read, mem_dq_oe stays low for at least TA_CYC = ceil(T_HZ/Tclk) cycles. A write accepted sooner lengthens its setup phase until this time has passed.
- R8: A request with req_be_n=11 asserts no strobe and no chip select, and done is high in the next cycle. For a read, rdata becomes 0.
- R9: A request is accepted only on an edge where idle is high. A request raised while a transfer is in progress is ignored and changes neither the memory pins nor the memory contents.
- R10: mem_be_n carries the request's lane mask for the whole transfer: bit 1 controls the upper lane (data bits 15:8), bit 0 the lower lane (bits 7:0), and 0 enables a lane. In rdata, the bits of a lane that was not enabled read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid, taken when idle is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be_n | input | 2 | Active-low lane mask (bit 1 upper, bit 0 lower) |
| idle | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done on reads |
| mem_addr | output | 18 | Memory address lines |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_be_n | output | 2 | Active-low byte-lane enables |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory pins |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
The bench starts a write right after a read, which is the case where the memory may still be driving the pins. A design that skipped the turnaround count would turn its drivers on inside the release window, and a bench model of the memory's drive time flags this. Writes with one lane enabled, followed by readback, show whether a lane mask leaks: a leak corrupts the other byte, or lets floating pin values into rdata. Requests with both lanes disabled and requests raised during a busy transfer are also sent: a design that pulsed a strobe for them, or started a second transfer, would fail the per-cycle pin comparison or later read back wrong contents.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and cycle arithmetic for the static RAM sequencer.
// Assumes timing values in whole nanoseconds and a clock period in picoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RWAIT  = 3'd4
    } seq_state_t;

    // Smallest number of clock cycles that covers t_ns.
    function automatic int cycles_for(input int t_ns, input int clk_ps);
        return (t_ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down counter that times each strobe phase.
// Assumes load has priority; expired is high once the count has reached zero.
module sram_phase_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_turn_timer.sv
// Counts off the time the memory may keep driving its pins after a read.
// Assumes load pulses on the edge where the output strobe is released;
// drive_ok allows the controller drivers on an edge TA_CYC or more edges later.
module sram_turn_timer #(
    parameter int CW     = 5,
    parameter int TA_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic drive_ok
);

    localparam logic [CW-1:0] TA_V = CW'(TA_CYC);

    logic [CW-1:0] cnt;

    // Restart the release window at the end of a read, then let it run out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= TA_V;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign drive_ok = (cnt <= CW'(1));

endmodule

// File: rtl/sram_lane_mask.sv
// Clears the byte lanes of the memory data that were not enabled.
// Assumes DW is NB whole lanes; a set lane_off bit clears that lane.
module sram_lane_mask #(
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic [DW-1:0] din,
    input  logic [NB-1:0] lane_off,
    output logic [DW-1:0] dout
);

    localparam int LW = DW / NB;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign dout[g*LW +: LW] = lane_off[g] ? '0 : din[g*LW +: LW];
    end

endmodule

// File: rtl/sram_seq.sv
// Transfer sequencer: accepts one request when idle and steps through the
// setup, strobe and hold phases, with every memory pin driven from a register.
// Assumes the phase timer expires RD/WP/HOLD cycles after each load and
// drive_ok reports that the memory has released the data pins.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 16,
    parameter int NB       = 2,
    parameter int CW       = 5,
    parameter int RD_CYC   = 19,
    parameter int WP_CYC   = 13,
    parameter int HOLD_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [NB-1:0] req_be_n,
    input  logic          phase_expired,
    input  logic          drive_ok,
    input  logic [DW-1:0] rd_lanes,
    output logic          phase_load,
    output logic [CW-1:0] phase_val,
    output logic          turn_load,
    output logic          idle,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [NB-1:0] mem_be_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe
);

    localparam logic [CW-1:0] RD_V = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WP_V = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] HD_V = CW'(HOLD_CYC - 1);

    seq_state_t state;

    logic accept;
    logic null_req;
    logic start_op;
    logic pulse_go;
    logic pulse_end;
    logic hold_end;
    logic read_end;

    // Phase decode for the current cycle.
    always_comb begin
        accept    = (state == ST_IDLE) && req;
        null_req  = &req_be_n;
        start_op  = accept && !null_req;
        pulse_go  = (state == ST_WSETUP) && drive_ok;
        pulse_end = (state == ST_WPULSE) && phase_expired;
        hold_end  = (state == ST_WHOLD) && phase_expired;
        read_end  = (state == ST_RWAIT) && phase_expired;
    end

    // Phase timer load and length select.
    always_comb begin
        phase_load = (start_op && !req_we) || pulse_go || pulse_end;
        if (pulse_go) begin
            phase_val = WP_V;
        end else if (pulse_end) begin
            phase_val = HD_V;
        end else begin
            phase_val = RD_V;
        end
    end

    assign turn_load = read_end;
    assign idle      = (state == ST_IDLE);

    // Transfer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (start_op)  state <= req_we ? ST_WSETUP : ST_RWAIT;
                ST_WSETUP: if (pulse_go)  state <= ST_WPULSE;
                ST_WPULSE: if (pulse_end) state <= ST_WHOLD;
                ST_WHOLD:  if (hold_end)  state <= ST_IDLE;
                ST_RWAIT:  if (read_end)  state <= ST_IDLE;
                default:                  state <= ST_IDLE;
            endcase
        end
    end

    // Chip selects, lane enables and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_be_n  <= '1;
        end else if (start_op) begin
            mem_addr  <= req_addr;
            mem_ce1_n <= 1'b0;
            mem_ce2   <= 1'b1;
            mem_be_n  <= req_be_n;
        end else if (hold_end || read_end) begin
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_be_n  <= '1;
        end
    end

    // Output and write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
        end else begin
            if (start_op && !req_we) mem_oe_n <= 1'b0;
            if (read_end)            mem_oe_n <= 1'b1;
            if (pulse_go)            mem_we_n <= 1'b0;
            if (pulse_end)           mem_we_n <= 1'b1;
        end
    end

    // Write data and the controller's data drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_dq_out <= '0;
            mem_dq_oe  <= 1'b0;
        end else begin
            if (start_op && req_we) mem_dq_out <= req_wdata;
            if (pulse_go)           mem_dq_oe  <= 1'b1;
            if (hold_end)           mem_dq_oe  <= 1'b0;
        end
    end

    // Completion pulse and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= (accept && null_req) || hold_end || read_end;
            if (accept && null_req && !req_we) rdata <= '0;
            if (read_end)                      rdata <= rd_lanes;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the static RAM sequencer: converts nanosecond timing into cycle
// counts and connects the sequencer, both timers and the read lane mask.
// Assumes DATA_W is a multiple of 8 and the clock period is given in ps.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int T_WP_NS       = 50,
    parameter int T_DW_NS       = 35,
    parameter int T_WC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_HZ_NS       = 25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be_n,
    output logic                  idle,
    output logic                  done,
    output logic [DATA_W-1:0]     rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce1_n,
    output logic                  mem_ce2,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [DATA_W-1:0]     mem_dq_out,
    input  logic [DATA_W-1:0]     mem_dq_in,
    output logic                  mem_dq_oe
);

    localparam int NB       = DATA_W / 8;
    localparam int WP_CYC   = max_of(cycles_for(T_WP_NS, CLK_PERIOD_PS),
                                     cycles_for(T_DW_NS, CLK_PERIOD_PS));
    localparam int RD_CYC   = cycles_for(T_AA_NS, CLK_PERIOD_PS) + 1;
    localparam int TA_CYC   = max_of(1, cycles_for(T_HZ_NS, CLK_PERIOD_PS));
    localparam int WC_CYC   = cycles_for(T_WC_NS, CLK_PERIOD_PS);
    localparam int HOLD_CYC = max_of(1, WC_CYC - WP_CYC - 1);
    localparam int MAX_CYC  = max_of(max_of(WP_CYC, RD_CYC), max_of(TA_CYC, HOLD_CYC));
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic          phase_load;
    logic [CW-1:0] phase_val;
    logic          phase_expired;
    logic          turn_load;
    logic          drive_ok;
    logic [DATA_W-1:0] rd_lanes;

    sram_phase_timer #(.CW(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .expired  (phase_expired)
    );

    sram_turn_timer #(.CW(CW), .TA_CYC(TA_CYC)) u_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (turn_load),
        .drive_ok (drive_ok)
    );

    sram_lane_mask #(.DW(DATA_W), .NB(NB)) u_mask (
        .din      (mem_dq_in),
        .lane_off (mem_be_n),
        .dout     (rd_lanes)
    );

    sram_seq #(
        .AW       (ADDR_W),
        .DW       (DATA_W),
        .NB       (NB),
        .CW       (CW),
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .req_we        (req_we),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .req_be_n      (req_be_n),
        .phase_expired (phase_expired),
        .drive_ok      (drive_ok),
        .rd_lanes      (rd_lanes),
        .phase_load    (phase_load),
        .phase_val     (phase_val),
        .turn_load     (turn_load),
        .idle          (idle),
        .done          (done),
        .rdata         (rdata),
        .mem_addr      (mem_addr),
        .mem_ce1_n     (mem_ce1_n),
        .mem_ce2       (mem_ce2),
        .mem_oe_n      (mem_oe_n),
        .mem_we_n      (mem_we_n),
        .mem_be_n      (mem_be_n),
        .mem_dq_out    (mem_dq_out),
        .mem_dq_oe     (mem_dq_oe)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
// Protocol checker for the memory-side pins of sram_async_ctrl.
// Assumes the same timing parameters as the top; bound to it below.
module sram_ctrl_checker
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int T_WP_NS       = 50,
    parameter int T_DW_NS       = 35,
    parameter int T_HZ_NS       = 25
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_ce1_n,
    input logic                mem_ce2,
    input logic                mem_oe_n,
    input logic                mem_we_n,
    input logic [DATA_W/8-1:0] mem_be_n,
    input logic                mem_dq_oe
);

    localparam int WP_CYC = max_of(cycles_for(T_WP_NS, CLK_PERIOD_PS),
                                   cycles_for(T_DW_NS, CLK_PERIOD_PS));
    localparam int TA_CYC = max_of(1, cycles_for(T_HZ_NS, CLK_PERIOD_PS));

    logic sel;
    int   we_low_cnt;
    int   oe_high_cnt;

    assign sel = !mem_ce1_n && mem_ce2;

    // Length of the current write-strobe low period.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_low_cnt <= 0;
        else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1;
        else                we_low_cnt <= 0;
    end

    // Cycles since the output strobe was released, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                   oe_high_cnt <= TA_CYC;
        else if (!mem_oe_n)           oe_high_cnt <= 0;
        else if (oe_high_cnt < TA_CYC) oe_high_cnt <= oe_high_cnt + 1;
    end

    assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (mem_we_n && mem_oe_n && (&mem_be_n)));

    assert_setup_before_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(sel) && $stable(mem_addr)));

    assert_hold_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> (sel && $stable(mem_addr)));

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= WP_CYC));

    assert_oe_held_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_drive_only_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (sel && mem_oe_n));

    assert_drive_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_high_cnt >= TA_CYC));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .T_WP_NS       (T_WP_NS),
    .T_DW_NS       (T_DW_NS),
    .T_HZ_NS       (T_HZ_NS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
// Bench: behavioural memory, a cycle reference model compared every clock,
// and directed plus pseudo-random request streams.
module tb_sram_async_ctrl;

    localparam int TCLK_PS = 4000;
    localparam int WP   = ((50000 + TCLK_PS - 1) / TCLK_PS > (35000 + TCLK_PS - 1) / TCLK_PS)
                          ? (50000 + TCLK_PS - 1) / TCLK_PS : (35000 + TCLK_PS - 1) / TCLK_PS;
    localparam int RD   = (70000 + TCLK_PS - 1) / TCLK_PS + 1;
    localparam int TA   = (25000 + TCLK_PS - 1) / TCLK_PS;
    localparam int WC   = (70000 + TCLK_PS - 1) / TCLK_PS;
    localparam int HOLD = (WC - WP - 1 < 1) ? 1 : WC - WP - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be_n = 2'b11;
    logic        idle, done;
    logic [15:0] rdata;
    logic [17:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be_n(req_be_n), .idle(idle), .done(done),
        .rdata(rdata), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- memory device model ----------------
    logic [15:0] dev_mem [0:63];
    logic [15:0] ref_mem [0:63];
    wire         dev_sel = !mem_ce1_n && mem_ce2;
    wire  [5:0]  dev_idx = mem_addr[5:0];

    always_comb begin
        if (dev_sel && !mem_oe_n && mem_we_n)
            mem_dq_in = {mem_be_n[1] ? 8'hEE : dev_mem[dev_idx][15:8],
                         mem_be_n[0] ? 8'hEE : dev_mem[dev_idx][7:0]};
        else
            mem_dq_in = 16'hDEAD;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) dev_mem[i] <= 16'(i * 16'h0101 + 16'h1000);
        end else if (dev_sel && !mem_we_n && mem_dq_oe) begin
            if (!mem_be_n[1]) dev_mem[dev_idx][15:8] <= mem_dq_out[15:8];
            if (!mem_be_n[0]) dev_mem[dev_idx][7:0]  <= mem_dq_out[7:0];
        end
    end

    // ---------------- cycle reference model ----------------
    int          m_st, m_cnt, m_age;
    logic [17:0] m_addr;
    logic [15:0] m_wd;
    logic [1:0]  m_be;
    logic        e_sel, e_oe_n, e_we_n, e_doe, e_done, e_idle;
    logic [1:0]  e_be;
    logic [17:0] e_addr;
    logic [15:0] e_dout, e_rdata;

    always @(posedge clk) begin
        bit rd_fin;
        rd_fin = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_age = 1000;
            e_sel = 0; e_oe_n = 1; e_we_n = 1; e_doe = 0; e_done = 0;
            e_be = 2'b11; e_addr = '0; e_dout = '0; e_rdata = '0;
            for (int i = 0; i < 64; i++) ref_mem[i] = 16'(i * 16'h0101 + 16'h1000);
        end else begin
            e_done = 0;
            case (m_st)
                0: if (req) begin
                    if (req_be_n == 2'b11) begin
                        e_done = 1;
                        if (!req_we) e_rdata = 16'h0;
                    end else begin
                        m_addr = req_addr; m_be = req_be_n; m_wd = req_wdata;
                        e_sel = 1; e_addr = req_addr; e_be = req_be_n;
                        if (req_we) begin
                            if (!req_be_n[1]) ref_mem[req_addr[5:0]][15:8] = req_wdata[15:8];
                            if (!req_be_n[0]) ref_mem[req_addr[5:0]][7:0]  = req_wdata[7:0];
                            m_st = 1;
                        end else begin
                            e_oe_n = 0; m_cnt = RD - 1; m_st = 4;
                        end
                    end
                end
                1: if (m_age >= TA) begin
                    e_we_n = 0; e_doe = 1; e_dout = m_wd; m_cnt = WP - 1; m_st = 2;
                end
                2: if (m_cnt == 0) begin e_we_n = 1; m_cnt = HOLD - 1; m_st = 3; end
                   else m_cnt--;
                3: if (m_cnt == 0) begin
                       e_doe = 0; e_sel = 0; e_be = 2'b11; e_done = 1; m_st = 0;
                   end else m_cnt--;
                4: if (m_cnt == 0) begin
                       e_oe_n = 1; e_sel = 0; e_be = 2'b11; e_done = 1; m_st = 0;
                       e_rdata = {m_be[1] ? 8'h00 : ref_mem[m_addr[5:0]][15:8],
                                  m_be[0] ? 8'h00 : ref_mem[m_addr[5:0]][7:0]};
                       rd_fin = 1'b1;
                   end else m_cnt--;
                default: m_st = 0;
            endcase
            if (rd_fin) m_age = 1;
            else if (m_age < 1000) m_age++;
        end
        e_idle = (m_st == 0);
    end

    // ---------------- per-cycle comparison and contention monitor ----------------
    int drv_left = 0;
    always @(negedge clk) begin
        if (dev_sel && !mem_oe_n && mem_we_n) drv_left = TA;
        else if (drv_left > 0) drv_left--;
        if (rst_n) begin
            chk({mem_ce1_n, mem_ce2} == {!e_sel, e_sel}, "R2 chip selects", {mem_ce1_n, mem_ce2}, {!e_sel, e_sel});
            chk(mem_we_n == e_we_n, "R4 write strobe", mem_we_n, e_we_n);
            chk(mem_oe_n == e_oe_n, "R3 output strobe", mem_oe_n, e_oe_n);
            chk(!(!mem_we_n && !mem_oe_n), "R5 strobes overlap", mem_oe_n, 1);
            chk(mem_dq_oe == e_doe, "R6 driver enable", mem_dq_oe, e_doe);
            if (e_doe) chk(mem_dq_out == e_dout, "R6 write data", mem_dq_out, e_dout);
            chk(done == e_done, "R3 done", done, e_done);
            chk(idle == e_idle, "R9 idle", idle, e_idle);
            chk(rdata == e_rdata, "R3 rdata", rdata, e_rdata);
            if (e_sel) begin
                chk(mem_be_n == e_be, "R10 lane enables", mem_be_n, e_be);
                chk(mem_addr == e_addr, "R4 address", mem_addr, e_addr);
            end
            chk(!(mem_dq_oe && drv_left > 0), "R7 bus contention", drv_left, 0);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_err++;
            $display("FAIL R9 watchdog: actual=%0d expected<%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        while (!idle) @(negedge clk);
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d; req_be_n = b;
        @(negedge clk);
        req = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic read_expect(input logic [17:0] a, input logic [1:0] b, input logic [15:0] exp, input string tag);
        issue(1'b0, a, 16'h0, b);
        chk(rdata == exp, tag, rdata, exp);
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (5) @(negedge clk);
        chk(mem_ce1_n == 1'b1, "R1 ce1_n in reset", mem_ce1_n, 1);
        chk(mem_ce2 == 1'b0, "R1 ce2 in reset", mem_ce2, 0);
        chk(mem_oe_n == 1'b1 && mem_we_n == 1'b1, "R1 strobes in reset", {mem_oe_n, mem_we_n}, 2'b11);
        chk(mem_be_n == 2'b11, "R1 lanes in reset", mem_be_n, 2'b11);
        chk(mem_dq_oe == 1'b0 && done == 1'b0 && idle == 1'b1, "R1 status in reset",
            {mem_dq_oe, done, idle}, 3'b001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(idle == 1'b1 && mem_ce1_n == 1'b1, "R1 after release", {idle, mem_ce1_n}, 2'b11);

        // Full-word write and readback (R3, R4).
        issue(1'b1, 18'h00001, 16'h1234, 2'b00);
        read_expect(18'h00001, 2'b00, 16'h1234, "R3 full word readback");

        // Upper-lane-only write, high address bits (R10).
        issue(1'b1, 18'h3FFC2, 16'hABCD, 2'b01);
        read_expect(18'h3FFC2, 2'b00, {8'hAB, 8'h02 + 8'h00}, "R10 upper lane write");
        // Read right after read then write: turnaround path (R7).
        issue(1'b1, 18'h00003, 16'h5AA5, 2'b10);
        read_expect(18'h00003, 2'b10, 16'h00A5, "R10 lower lane read masks upper");
        read_expect(18'h00003, 2'b01, 16'h1000 + 16'h0300 & 16'hFF00, "R10 upper lane read masks lower");

        // Null requests (R8).
        issue(1'b1, 18'h00004, 16'hFFFF, 2'b11);
        read_expect(18'h00004, 2'b11, 16'h0000, "R8 null read gives zero");
        read_expect(18'h00004, 2'b00, 16'h1404, "R8 null write left memory unchanged");

        // Request while busy is ignored (R9).
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 18'h00005; req_wdata = 16'h7777; req_be_n = 2'b00;
        @(negedge clk);
        req_addr = 18'h00006; req_wdata = 16'h9999;
        repeat (3) @(negedge clk);
        req = 1'b0;
        while (!done) @(negedge clk);
        read_expect(18'h00006, 2'b00, 16'h1606, "R9 busy request ignored");
        read_expect(18'h00005, 2'b00, 16'h7777, "R9 first request written");

        // Pseudo-random stream (all requirements via the reference model).
        lfsr = 16'hACE1;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[0], {lfsr[11:0], 3'b000, lfsr[3:1]}, lfsr ^ 16'h5A5A, lfsr[9:8]);
        end

        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule